// File: doc/BRIEF.md
# Prescaled GPIO Input Debouncer

This block cleans up to 32 general-purpose input lines before they reach interrupt edge and level detection. The pins first pass through a two-flop synchroniser. One shared prescaler counts bus-clock cycles and issues a single-cycle sampling tick every P cycles, where P is a 24-bit programmable value. Each line has its own enable bit. An enabled line changes its filtered value only after the synchronised input has held a new value across two consecutive ticks. A disabled line passes its synchronised value straight through.

The debounced value matters only where interrupt detection is active, so software turns filtering on only for interrupt sources. The data-in register always returns the synchronised, unfiltered pins. Software chooses the tick rate: the tick frequency is the bus clock divided by P. For example, P = 2000 on a 66 MHz bus gives a tick rate of about 33 kHz.

Each line runs a two-state machine. In state SETTLED the line has no pending change. The transition SETTLED->PENDING fires on a tick when the line is enabled and the sample differs from the filtered output. In state PENDING, the next tick always leads back to SETTLED by one of two transitions. PENDING->SETTLED (commit) fires when the sample still differs, and the filtered output flips. PENDING->SETTLED (abort) fires when the sample has returned to the output value. Clearing the enable forces any state back to SETTLED. While the line is disabled, the stored filtered value tracks the synchronised input.

Top module: `gpio_debounce`

## Requirements
- R1: After reset every enable bit is 0, the prescale register reads 0, and each filtered output equals its synchronised pin.
- R2: Byte offset 0x40 holds the enable mask, with bit i controlling line i. Byte offset 0x44 holds the prescale value. Both read back what was written.
- R3: The prescale register is 24 bits wide. Data bits 31:24 of a write are dropped and read back as 0.
- R4: With a prescale value P of 2 or more, a tick occurs every P cycles. A value of 0 or 1 gives a tick on every cycle. With P of 0 or 1, an enabled line's filtered output follows a held pin change exactly 4 clock edges after the change.
- R5: Writing the prescale register restarts the prescaler from zero. After a write captured at edge W with value P, ticks fall on edges W+P, W+2P, and so on.
- R6: An enabled line's filtered output changes only on a tick, and only when that tick's sample and the previous tick's sample agree and both differ from the output. A level held for 2P+2 edges always gets through. A level held for P+2 edges or fewer has not yet changed the output.
- R7: On an enabled line, a pulse shorter than the tick interval never reaches the filtered output.
- R8: A disabled line's filtered output equals its synchronised pin, 2 edges after the pin changes, with no filtering. A one-cycle glitch therefore passes through.
- R9: Byte offset 0x04 reads the synchronised, unfiltered pins whatever the enables are.
- R10: Lines are independent. Enabled and disabled lines in the same word each follow their own rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Raw asynchronous input pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational; unmapped offsets read 0 |
| filt_out | output | 32 | Per-line filtered values toward interrupt detection |

## Verification
The hardest situation to reach from the ports is a change that arrives at a known point in the tick phase. The prescaler's phase is not visible from outside, so a timing check cannot be exact while the phase is unknown. The bench first parks the prescaler on a very long interval and lets a pin change settle through the synchroniser. It then writes a short prescale value, which sets the phase at a known edge, and checks the commit on the exact edge after that write. Where the phase is left free, the bench checks only the guaranteed bounds: unchanged after P+1 edges, changed after 2P+3 edges, and a pulse shorter than P rejected.

// File: rtl/gpdb_pkg.sv
package gpdb_pkg;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_RAW = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_EN  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_PRE = 8'h44;

    typedef enum logic {
        DB_SETTLED = 1'b0,
        DB_PENDING = 1'b1
    } db_state_e;
endpackage

// File: rtl/gpdb_sync.sv
module gpdb_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpdb_prescaler.sv
module gpdb_prescaler #(
    parameter int unsigned PRE_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             restart,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    // Values 0 and 1 both mean a tick on every cycle
    assign limit = (pre_val <= PRE_W'(1)) ? '0 : pre_val - PRE_W'(1);
    assign tick  = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/gpdb_regs.sv
module gpdb_regs
    import gpdb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PRE_W     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [NUM_LINES-1:0] raw_sync,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_LINES-1:0] en_q,
    output logic [PRE_W-1:0]     pre_q,
    output logic                 pre_wr
);
    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:PRE_W];

    assign pre_wr = wr_en && (wr_addr == OFS_PRE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pre_q <= '0;
        end else begin
            if (wr_en && (wr_addr == OFS_EN)) begin
                en_q <= wr_data[NUM_LINES-1:0];
            end
            if (pre_wr) begin
                pre_q <= wr_data[PRE_W-1:0];
            end
        end
    end

    always_comb begin
        case (rd_addr)
            OFS_RAW: rd_data = DATA_W'(raw_sync);
            OFS_EN:  rd_data = DATA_W'(en_q);
            OFS_PRE: rd_data = DATA_W'(pre_q);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpdb_line.sv
module gpdb_line
    import gpdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic sample,
    output logic filt
);
    db_state_e state_q, state_d;
    logic      filt_q;
    logic      commit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_SETTLED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            DB_SETTLED: begin
                if (en && tick && (sample != filt_q)) begin
                    state_d = DB_PENDING;
                end
            end
            DB_PENDING: begin
                if (!en) begin
                    state_d = DB_SETTLED;
                end else if (tick) begin
                    state_d = DB_SETTLED;
                    commit  = (sample != filt_q);
                end
            end
            default: state_d = DB_SETTLED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
        end else if (!en) begin
            filt_q <= sample;
        end else if (commit) begin
            filt_q <= ~filt_q;
        end
    end

    assign filt = en ? filt_q : sample;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import gpdb_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned PRE_W       = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_in,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_LINES-1:0] filt_out
);
    logic [NUM_LINES-1:0] sync_q;
    logic [NUM_LINES-1:0] en_q;
    logic [PRE_W-1:0]     pre_q;
    logic                 pre_wr;
    logic                 tick;

    gpdb_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
    );

    gpdb_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .raw_sync(sync_q),
        .rd_data(rd_data), .en_q(en_q), .pre_q(pre_q), .pre_wr(pre_wr)
    );

    gpdb_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .pre_val(pre_q), .restart(pre_wr), .tick(tick)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        gpdb_line u_line (
            .clk(clk), .rst_n(rst_n), .en(en_q[i]), .tick(tick),
            .sample(sync_q[i]), .filt(filt_out[i])
        );
    end
endmodule

// File: rtl/gpdb_checker.sv
module gpdb_checker
    import gpdb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PRE_W     = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] line_en,
    input logic                 tick,
    input logic [NUM_LINES-1:0] filt,
    input logic [NUM_LINES-1:0] raw,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic [DATA_W-1:0]    rd_data
);
    // R1: enables are held at zero while reset stays asserted
    a_r1_reset_enables: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (line_en == '0));

    // R8: disabled lines mirror the synchronised input
    a_r8_disabled_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (((filt ^ raw) & ~line_en) == '0));

    // R6: an enabled line only moves on a tick
    a_r6_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (((filt ^ $past(filt)) & line_en & $past(line_en)) != '0) |-> $past(tick));

    // R6: an enabled line moves to the value the sampled input held
    a_r6_change_matches_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (((filt ^ $past(filt)) & line_en & $past(line_en)) != '0) |->
        ((($past(raw) ^ filt) & line_en & $past(line_en) & (filt ^ $past(filt))) == '0));

    // R3: the prescale register never shows bits above its width
    a_r3_prescale_width: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == OFS_PRE) |-> (rd_data[DATA_W-1:PRE_W] == '0));
endmodule

bind gpio_debounce gpdb_checker #(
    .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .PRE_W(PRE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_en(en_q), .tick(tick), .filt(filt_out),
    .raw(sync_q), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/gpio_debounce_tb.sv
`timescale 1ns/1ps
module gpio_debounce_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] filt_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gpio_debounce u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .filt_out(filt_out)
    );

    // pins[71:40], edges to wait[39:32], expected filt_out[31:0]
    // prescale 0, lines 15:0 enabled, lines 31:16 disabled
    localparam logic [71:0] VEC [8] = '{
        {32'hFFFF_FFFF, 8'd3, 32'hFFFF_0000},
        {32'hFFFF_FFFF, 8'd1, 32'hFFFF_FFFF},
        {32'h0000_0000, 8'd1, 32'hFFFF_FFFF},
        {32'hFFFF_FFFF, 8'd6, 32'hFFFF_FFFF},
        {32'hA5A5_A5A5, 8'd2, 32'hA5A5_FFFF},
        {32'hA5A5_A5A5, 8'd2, 32'hA5A5_A5A5},
        {32'h1234_5678, 8'd4, 32'h1234_5678},
        {32'h0000_0000, 8'd5, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        check("R1 filt", filt_out, 32'h0);
        rd(8'h40, r); check("R1 enables", r, 32'h0);
        rd(8'h44, r); check("R1 prescale", r, 32'h0);

        // R2 and R3 register access
        wr(8'h40, 32'h0000_FFFF);
        rd(8'h40, r); check("R2 enable readback", r, 32'h0000_FFFF);
        wr(8'h44, 32'hFF00_0003);
        rd(8'h44, r); check("R3 prescale truncation", r, 32'h0000_0003);
        wr(8'h44, 32'h0);

        // R10, R8, R4 table walk
        for (int v = 0; v < 8; v++) begin
            pin_in = VEC[v][71:40];
            edges(int'(VEC[v][39:32]));
            check($sformatf("R10/R8/R4 vector %0d", v), filt_out, VEC[v][31:0]);
        end

        // R4: prescale 1 gives exact 4-edge latency on an enabled line
        wr(8'h40, 32'h0000_0001);
        wr(8'h44, 32'd1);
        pin_in = 32'h1;
        edges(3);
        check("R4 pre1 before", filt_out, 32'h0);
        edges(1);
        check("R4 pre1 after", filt_out, 32'h1);

        // R5: a prescale write restarts the counter
        pin_in = 32'h0;
        edges(6);
        wr(8'h44, 32'd1000);
        edges(2);
        pin_in = 32'h1;
        edges(5);
        wr(8'h44, 32'd6);
        edges(11);
        check("R5 restart W+11", filt_out, 32'h0);
        edges(1);
        check("R5 restart W+12", filt_out, 32'h1);

        // R6: bounds with prescale 8
        wr(8'h44, 32'd8);
        pin_in = 32'h0;
        edges(9);
        check("R6 held P+1", filt_out, 32'h1);
        edges(10);
        check("R6 held 2P+3", filt_out, 32'h0);

        // R7: a pulse shorter than the tick interval is rejected
        pin_in = 32'h1;
        edges(5);
        pin_in = 32'h0;
        edges(30);
        check("R7 short pulse", filt_out, 32'h0);

        // R9: raw register shows unfiltered pins
        wr(8'hFF, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'd1000);
        pin_in = 32'h5A5A_0F0F;
        edges(2);
        rd(8'h04, r); check("R9 raw read", r, 32'h5A5A_0F0F);
        check("R9 filtered held", filt_out, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule